// File: doc/BRIEF.md
# I2C Target Receive Engine

This block is the receive side of an I2C target. It watches the open-drain SDA and SCL lines, spots START, repeated START and STOP, and answers either a 7-bit or a 10-bit own address. It then shifts in data bytes and acknowledges each one by pulling SDA low during the ninth clock. It oversamples both lines with a system clock at least eight times the SCL rate. Each line passes through a two-flop synchronizer before any edge is decoded. Both lines are driven only as drive-low enables.

Each accepted data byte goes into a single receive buffer. The buffer is unloaded over a valid/ready stream port. `rx_valid` is the buffer-full flag. The data stays stable while `rx_valid` is high and `rx_ready` is low, and one cycle with both high empties the buffer. The engine cannot wait on the line for the consumer, so back-pressure does not stall the bus. A byte that arrives while the buffer is full, or while the sticky overflow flag is set, is answered with NACK and thrown away, and the overflow flag is set.

With stretching enabled, a buffer that is still full at the falling edge of the ninth clock makes the engine clear its SCL-release bit and hold SCL low. Software can also clear that bit at any time to park the bus, and sets it again to let SCL go.

Top module: `i2c_tgt_rx`

## Requirements
- R1: After reset `rx_valid`, `ovf`, `irq`, `scl_oe` and `sda_oe` are 0 and `scl_rel` is 1.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A byte after START whose address does not match is NACKed with no `irq`, and every byte is then ignored until the next START.
- R3: With `addr10_en`=0, the first byte after START carries the address in bits 7:1 and R/W in bit 0. On a match with `own_addr[6:0]` the byte is ACKed and gives one `irq` pulse, with `is_data`=0 and `rw_flag` set to bit 0. If R/W=1, later bytes are ignored until the next START or STOP.
- R4: With `addr10_en`=1, the first byte must be `11110` followed by `own_addr[9:8]` and then 0. It is ACKed with no `irq`. The second byte must equal `own_addr[7:0]`. It is ACKed with one `irq`, `is_data`=0 and `rw_flag`=0. A mismatch in either byte gives NACK, and later bytes are ignored until the next START.
- R5: A data byte that arrives with the buffer empty and `ovf`=0 is ACKed. It then appears on `rx_data` with `rx_valid`=1 and `is_data`=1, and it raises one `irq` pulse.
- R6: `rx_data` holds steady while `rx_valid`=1 and `rx_ready`=0. A cycle with `rx_valid` and `rx_ready` both high drops `rx_valid` on the next cycle.
- R7: A data byte that arrives while the buffer is full is NACKed with no `irq`. It sets `ovf` and leaves `rx_data` unchanged. Every further such byte is handled the same way.
- R8: Popping the buffer does not clear `ovf`. While `ovf`=1 a data byte is NACKed even if the buffer is empty. A one-cycle `ovf_clr` pulse clears `ovf`.
- R9: After a pop and an `ovf_clr`, the next data byte is stored and ACKed.
- R10: With `stretch_en`=0, hardware never clears `scl_rel` and SCL is not held after a data byte.
- R11: With `stretch_en`=1, if `rx_valid`=1 at the falling edge of the ninth clock of a data byte, `scl_rel` goes to 0. SCL is then held low (`scl_oe`=1) until a `rel_set` pulse. Address bytes never cause a stretch.
- R12: If the buffer is popped before the ninth falling edge, no stretch occurs.
- R13: A `rel_clr` pulse clears `scl_rel` at any time. SCL is driven low only once SCL is seen low, and it stays driven until `rel_set`.
- R14: `irq` is a single-cycle pulse, raised once for each accepted address phase or data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 (ACK) |
| own_addr | input | 10 | Own target address, bits 6:0 used in 7-bit mode |
| addr10_en | input | 1 | 1 selects 10-bit addressing |
| stretch_en | input | 1 | 1 enables stretching on a full buffer |
| rel_set | input | 1 | Pulse: set the SCL-release bit |
| rel_clr | input | 1 | Pulse: clear the SCL-release bit |
| ovf_clr | input | 1 | Pulse: clear the overflow flag |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Consumer takes the buffer |
| rx_data | output | 8 | Receive buffer contents |
| ovf | output | 1 | Sticky overflow flag |
| is_data | output | 1 | Last accepted byte was data (1) or address (0) |
| rw_flag | output | 1 | R/W bit of the last accepted address |
| scl_rel | output | 1 | SCL-release bit |
| irq | output | 1 | One-cycle pulse per accepted byte |

## Verification
The hardest state to reach is a pop that lands between the falling edge of the eighth clock, where the byte is stored, and the falling edge of the ninth clock, where the stretch decision is taken. Reaching it needs a host that can act in the middle of its own acknowledge clock. The bench host model does this: it pulses `rx_ready` while the ninth SCL is high, and it waits for SCL to read high before it goes on, so it also survives a stretch.

The second hard state is a flag that outlives the buffer: the buffer has been popped but `ovf` is still set. Directed traffic sends bytes while `ovf_clr` is held back. Seeded random traffic then mixes pops and clears between bytes, and a bench-side buffer model predicts each ACK.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W     = 8;
  localparam int BITCNT_W   = $clog2(BYTE_W + 1);
  localparam int TEN_ADDR_W = 10;
  localparam int HDR_W      = BYTE_W - 3;
  localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_ACK, ST_SKIP} bus_st_e;
  typedef enum logic [1:0] {PH_ADDR1, PH_ADDR2, PH_DATA} phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int N      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [STAGES:0][N-1:0] pipe;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= '1;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q      = pipe[STAGES-1];
  assign q_prev = pipe[STAGES];
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_tgt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl,
  input  logic                  scl_prev,
  input  logic                  sda,
  input  logic                  sda_prev,
  input  logic [TEN_ADDR_W-1:0] own_addr,
  input  logic                  addr10_en,
  input  logic                  buf_busy,
  output logic                  sda_oe,
  output logic                  addr_hit,
  output logic                  hit_rw,
  output logic                  data_push,
  output logic                  data_drop,
  output logic                  ninth_fall,
  output logic [BYTE_W-1:0]     rx_byte
);
  bus_st_e              st;
  phase_e               ph, ph_after_q, ph_next;
  logic                 skip_q, skip_next;
  logic [BITCNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0]    shreg;
  logic scl_rise, scl_fall, start_c, stop_c, byte_end;
  logic ack, match7, hdr_ok, low_ok;

  assign scl_rise = scl & ~scl_prev;
  assign scl_fall = ~scl & scl_prev;
  assign start_c  = scl & scl_prev & sda_prev & ~sda;
  assign stop_c   = scl & scl_prev & ~sda_prev & sda;
  assign byte_end = (st == ST_SHIFT) && scl_fall && (bitcnt == BITCNT_W'(BYTE_W));

  assign match7 = shreg[BYTE_W-1:1] == own_addr[BYTE_W-2:0];
  assign hdr_ok = (shreg[BYTE_W-1:3] == TEN_HDR) &&
                  (shreg[2:1] == own_addr[TEN_ADDR_W-1:BYTE_W]) && !shreg[0];
  assign low_ok = shreg == own_addr[BYTE_W-1:0];

  always_comb begin
    ack       = 1'b0;
    ph_next   = PH_DATA;
    skip_next = 1'b0;
    case (ph)
      PH_ADDR1: begin
        if (addr10_en) begin
          ack       = hdr_ok;
          ph_next   = PH_ADDR2;
          skip_next = !hdr_ok;
        end else begin
          ack       = match7;
          skip_next = !match7 || shreg[0];
        end
      end
      PH_ADDR2: begin
        ack       = low_ok;
        skip_next = !low_ok;
      end
      default: ack = !buf_busy;
    endcase
  end

  assign addr_hit   = byte_end && ack &&
                      (((ph == PH_ADDR1) && !addr10_en) || (ph == PH_ADDR2));
  assign hit_rw     = (ph == PH_ADDR1) ? shreg[0] : 1'b0;
  assign data_push  = byte_end && (ph == PH_DATA) && !buf_busy;
  assign data_drop  = byte_end && (ph == PH_DATA) && buf_busy;
  assign ninth_fall = (st == ST_ACK) && scl_fall && (ph == PH_DATA);
  assign rx_byte    = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      ph         <= PH_ADDR1;
      ph_after_q <= PH_ADDR1;
      skip_q     <= 1'b0;
      bitcnt     <= '0;
      shreg      <= '0;
      sda_oe     <= 1'b0;
    end else if (start_c) begin
      st     <= ST_SHIFT;
      ph     <= PH_ADDR1;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_SHIFT: begin
          if (scl_rise && (bitcnt < BITCNT_W'(BYTE_W))) begin
            shreg  <= {shreg[BYTE_W-2:0], sda};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_end) begin
            sda_oe     <= ack;
            ph_after_q <= ph_next;
            skip_q     <= skip_next;
            st         <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            ph     <= ph_after_q;
            st     <= skip_q ? ST_SKIP : ST_SHIFT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rx_store.sv
module i2c_rx_store
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_hit,
  input  logic              hit_rw,
  input  logic              data_push,
  input  logic              data_drop,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_ready,
  input  logic              ovf_clr,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ovf,
  output logic              is_data,
  output logic              rw_flag,
  output logic              irq,
  output logic              busy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      ovf      <= 1'b0;
      is_data  <= 1'b0;
      rw_flag  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= addr_hit | data_push;
      if (addr_hit) begin
        is_data <= 1'b0;
        rw_flag <= hit_rw;
      end
      if (data_push) begin
        rx_data  <= rx_byte;
        rx_valid <= 1'b1;
        is_data  <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (data_drop)    ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  assign busy = rx_valid | ovf;
endmodule

// File: rtl/i2c_scl_hold.sv
module i2c_scl_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic ninth_fall,
  input  logic full,
  input  logic stretch_en,
  input  logic rel_set,
  input  logic rel_clr,
  output logic scl_rel,
  output logic scl_oe
);
  logic hw_stretch;

  assign hw_stretch = ninth_fall && stretch_en && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_rel <= 1'b1;
      scl_oe  <= 1'b0;
    end else begin
      if (hw_stretch || rel_clr) scl_rel <= 1'b0;
      else if (rel_set)          scl_rel <= 1'b1;
      if (scl_rel)   scl_oe <= 1'b0;
      else if (!scl) scl_oe <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tgt_rx.sv
module i2c_tgt_rx
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  scl_oe,
  output logic                  sda_oe,
  input  logic [TEN_ADDR_W-1:0] own_addr,
  input  logic                  addr10_en,
  input  logic                  stretch_en,
  input  logic                  rel_set,
  input  logic                  rel_clr,
  input  logic                  ovf_clr,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [BYTE_W-1:0]     rx_data,
  output logic                  ovf,
  output logic                  is_data,
  output logic                  rw_flag,
  output logic                  scl_rel,
  output logic                  irq
);
  logic [1:0] line_q, line_p;
  logic addr_hit, hit_rw, data_push, data_drop, ninth_fall, busy;
  logic [BYTE_W-1:0] rx_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .q(line_q), .q_prev(line_p)
  );

  i2c_rx_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl(line_q[1]), .scl_prev(line_p[1]), .sda(line_q[0]), .sda_prev(line_p[0]),
    .own_addr(own_addr), .addr10_en(addr10_en), .buf_busy(busy),
    .sda_oe(sda_oe), .addr_hit(addr_hit), .hit_rw(hit_rw),
    .data_push(data_push), .data_drop(data_drop), .ninth_fall(ninth_fall),
    .rx_byte(rx_byte)
  );

  i2c_rx_store u_store (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .hit_rw(hit_rw),
    .data_push(data_push), .data_drop(data_drop), .rx_byte(rx_byte),
    .rx_ready(rx_ready), .ovf_clr(ovf_clr), .rx_valid(rx_valid),
    .rx_data(rx_data), .ovf(ovf), .is_data(is_data), .rw_flag(rw_flag),
    .irq(irq), .busy(busy)
  );

  i2c_scl_hold u_hold (
    .clk(clk), .rst_n(rst_n), .scl(line_q[1]), .ninth_fall(ninth_fall),
    .full(rx_valid), .stretch_en(stretch_en), .rel_set(rel_set),
    .rel_clr(rel_clr), .scl_rel(scl_rel), .scl_oe(scl_oe)
  );
endmodule

// File: rtl/i2c_tgt_rx_chk.sv
module i2c_tgt_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_push,
  input logic       data_drop,
  input logic       ninth_fall,
  input logic       stretch_en,
  input logic       rel_clr,
  input logic       ovf_clr,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       ovf,
  input logic       is_data,
  input logic       sda_oe,
  input logic       scl_rel,
  input logic       scl_oe,
  input logic       irq
);
  AST_PUSH_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    data_push |=> rx_valid && is_data && sda_oe); // R5
  AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)); // R6
  AST_DROP_NACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_drop |=> ovf && !sda_oe && $stable(rx_data)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf); // R8
  AST_NO_HW_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rel && !stretch_en && !rel_clr |=> scl_rel); // R10
  AST_STRETCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ninth_fall && stretch_en && rx_valid |=> !scl_rel); // R11
  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rel |=> !scl_oe); // R13
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R14
endmodule

bind i2c_tgt_rx i2c_tgt_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_push(data_push), .data_drop(data_drop),
  .ninth_fall(ninth_fall), .stretch_en(stretch_en), .rel_clr(rel_clr),
  .ovf_clr(ovf_clr), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .ovf(ovf), .is_data(is_data), .sda_oe(sda_oe),
  .scl_rel(scl_rel), .scl_oe(scl_oe), .irq(irq)
);

// File: tb/sim_i2c_tgt_rx.sv
module sim_i2c_tgt_rx;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_scl = 1'b0, h_sda = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [9:0] own_addr = 10'h02C;
  logic addr10_en = 1'b0, stretch_en = 1'b0;
  logic rel_set = 1'b0, rel_clr = 1'b0, ovf_clr = 1'b0, rx_ready = 1'b0;
  logic rx_valid, ovf, is_data, rw_flag, scl_rel, irq;
  logic [7:0] rx_data;
  int n_chk = 0, n_err = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign scl_line = !(h_scl | scl_oe);
  assign sda_line = !(h_sda | sda_oe);

  i2c_tgt_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .addr10_en(addr10_en),
    .stretch_en(stretch_en), .rel_set(rel_set), .rel_clr(rel_clr), .ovf_clr(ovf_clr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .ovf(ovf),
    .is_data(is_data), .rw_flag(rw_flag), .scl_rel(scl_rel), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  function automatic bit predict_ack(input bit full, input bit sticky);
    return !(full | sticky);
  endfunction

  function automatic logic [7:0] addr7_byte(input logic [6:0] a, input bit rw);
    return {a, rw};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    h_scl = 1'b0;
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    h_sda = 1'b0; tick(Q); scl_up(); tick(Q);
    h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q);
  endtask

  task automatic bus_stop();
    h_sda = 1'b1; tick(Q); scl_up(); tick(Q); h_sda = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit pop_mid,
                           output bit ack, output logic [7:0] popped);
    popped = '0;
    for (int i = 7; i >= 0; i--) begin
      h_sda = !b[i]; tick(Q); scl_up(); tick(2*Q); h_scl = 1'b1; tick(2);
    end
    h_sda = 1'b0; tick(Q); scl_up(); tick(Q);
    ack = !sda_line;
    if (pop_mid) begin
      popped = rx_data; rx_ready = 1'b1; tick(1); rx_ready = 1'b0; tick(Q-1);
    end else tick(Q);
    h_scl = 1'b1; tick(Q);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(1); s = 1'b0; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] pb;
    int ic;
    bit m_full, m_ovf;
    logic [7:0] m_buf;
    int rs;
    rs = $urandom(32'd24681);
    tick(5); rst_n = 1'b1; tick(4);
    // R1 reset state
    check("R1 rx_valid", rx_valid, 0);
    check("R1 ovf", ovf, 0);
    check("R1 scl_rel", scl_rel, 1);
    check("R1 oe", {scl_oe, sda_oe, irq}, 0);

    // R3 R5 R6 R7 R8 R9 R10 seven-bit receive with overrun
    bus_start();
    ic = irq_cnt;
    send_byte(addr7_byte(7'h2C, 0), 0, ack, pb);
    check("R3 addr ack", ack, 1);
    check("R3 irq once", irq_cnt - ic, 1);
    check("R3 flags", {is_data, rw_flag}, 2'b00);
    check("R11 no stretch on address", scl_rel, 1);
    ic = irq_cnt;
    send_byte(8'hA5, 0, ack, pb);
    check("R5 ack", ack, 1);
    check("R5 data", {rx_valid, is_data, rx_data}, {2'b11, 8'hA5});
    check("R5 irq", irq_cnt - ic, 1);
    tick(3); check("R6 stable", rx_data, 8'hA5);
    pulse(rx_ready);
    check("R6 pop", rx_valid, 0);
    send_byte(8'h3C, 0, ack, pb);
    check("R5 second", {ack, rx_data}, {1'b1, 8'h3C});
    check("R10 no stretch", {scl_rel, scl_oe}, 2'b10);
    ic = irq_cnt;
    send_byte(8'h77, 0, ack, pb);
    check("R7 nack", ack, 0);
    check("R7 ovf keep", {ovf, rx_data}, {1'b1, 8'h3C});
    check("R7 no irq", irq_cnt - ic, 0);
    send_byte(8'h88, 0, ack, pb);
    check("R7 second nack", {ack, rx_data}, {1'b0, 8'h3C});
    pulse(rx_ready);
    check("R8 pop keeps ovf", {rx_valid, ovf}, 2'b01);
    send_byte(8'h99, 0, ack, pb);
    check("R8 nack empty buffer", {ack, rx_valid}, 2'b00);
    pulse(ovf_clr);
    check("R8 cleared", ovf, 0);
    send_byte(8'h42, 0, ack, pb);
    check("R9 resume", {ack, rx_valid, rx_data}, {2'b11, 8'h42});
    pulse(rx_ready);
    bus_stop();

    // R2 unaddressed
    bus_start();
    ic = irq_cnt;
    send_byte(addr7_byte(7'h11, 0), 0, ack, pb);
    check("R2 nack", ack, 0);
    send_byte(8'h55, 0, ack, pb);
    check("R2 ignored", {ack, rx_valid}, 2'b00);
    check("R2 no irq", irq_cnt - ic, 0);
    bus_stop();

    // R3 read request
    bus_start();
    ic = irq_cnt;
    send_byte(addr7_byte(7'h2C, 1), 0, ack, pb);
    check("R3 read ack", {ack, rw_flag, is_data}, 3'b110);
    check("R3 read irq", irq_cnt - ic, 1);
    send_byte(8'h12, 0, ack, pb);
    check("R3 read ignores", {ack, rx_valid}, 2'b00);
    bus_stop();

    // R4 ten-bit addressing
    own_addr = 10'h2B7; addr10_en = 1'b1;
    bus_start();
    ic = irq_cnt;
    send_byte(8'hF4, 0, ack, pb);
    check("R4 header ack", ack, 1);
    check("R4 header no irq", irq_cnt - ic, 0);
    send_byte(8'hB7, 0, ack, pb);
    check("R4 low ack", {ack, is_data, rw_flag}, 3'b100);
    check("R4 low irq", irq_cnt - ic, 1);
    send_byte(8'h1E, 0, ack, pb);
    check("R4 data", {ack, rx_data}, {1'b1, 8'h1E});
    pulse(rx_ready);
    bus_start();
    send_byte(8'hF4, 0, ack, pb);
    send_byte(8'hB6, 0, ack, pb);
    check("R4 low mismatch", ack, 0);
    send_byte(8'h21, 0, ack, pb);
    check("R4 ignored", {ack, rx_valid}, 2'b00);
    bus_stop();
    bus_start();
    send_byte(8'hF0, 0, ack, pb);
    check("R4 header mismatch", ack, 0);
    bus_stop();
    own_addr = 10'h02C; addr10_en = 1'b0;

    // R11 R12 stretching
    stretch_en = 1'b1;
    bus_start();
    send_byte(addr7_byte(7'h2C, 0), 0, ack, pb);
    check("R11 address no stretch", {scl_rel, scl_oe}, 2'b10);
    send_byte(8'hC3, 0, ack, pb);
    check("R11 stretch", {scl_rel, scl_oe}, 2'b01);
    tick(40);
    check("R11 still held", {scl_oe, scl_line}, 2'b10);
    pulse(rx_ready);
    pulse(rel_set);
    tick(4);
    check("R11 released", {scl_rel, scl_oe}, 2'b10);
    send_byte(8'h5D, 1, ack, pb);
    check("R12 popped", {ack, pb}, {1'b1, 8'h5D});
    check("R12 no stretch", {scl_rel, scl_oe, rx_valid}, 3'b100);
    // R13 software suspend while SCL low
    pulse(rel_clr); tick(4);
    check("R13 hold low", {scl_rel, scl_oe}, 2'b01);
    pulse(rel_set); tick(3);
    check("R13 free", scl_oe, 0);
    bus_stop();
    stretch_en = 1'b0;
    // R13 with SCL high: no drive until low
    pulse(rel_clr); tick(10);
    check("R13 waits for low", {scl_rel, scl_oe}, 2'b00);
    pulse(rel_set); tick(3);

    // Seeded random traffic, R5 R7 R8 R9
    m_full = 0; m_ovf = 0; m_buf = 8'h00;
    for (int t = 0; t < 20; t++) begin
      bit hit;
      logic [6:0] a;
      hit = ($urandom % 4) != 0;
      a = hit ? 7'h2C : 7'($urandom);
      if (!hit && a == 7'h2C) a = 7'h2D;
      bus_start();
      send_byte(addr7_byte(a, 0), 0, ack, pb);
      check("R2 random address", ack, hit);
      if (hit) begin
        for (int k = 0; k < 1 + int'($urandom % 4); k++) begin
          logic [7:0] b;
          bit ea;
          b = 8'($urandom);
          ea = predict_ack(m_full, m_ovf);
          send_byte(b, 0, ack, pb);
          check("R7 random ack", ack, ea);
          if (ea) begin m_full = 1; m_buf = b; end
          else m_ovf = 1;
          check("R8 random ovf", ovf, m_ovf);
          if (m_full) check("R5 random data", rx_data, m_buf);
          case ($urandom % 4)
            0: begin pulse(rx_ready); m_full = 0; end
            1: begin pulse(ovf_clr); m_ovf = 0; end
            2: begin pulse(rx_ready); pulse(ovf_clr); m_full = 0; m_ovf = 0; end
            default: ;
          endcase
          check("R6 random valid", rx_valid, m_full);
        end
      end
      bus_stop();
    end
    pulse(rx_ready); pulse(ovf_clr);
    check("R14 irq idle", irq, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule